// File: doc/BRIEF.md
# Register-Built Multiport Memory

This block is a small memory in which every word is an ordinary register. Several write ports and several read ports reach it at once. All writes happen on one clock edge. Each write port carries an address, a data word and one enable bit per data bit. When two ports touch the same bit in the same cycle, the port with the higher index wins. A base offset is subtracted from every address before decoding, so the array answers only to a window of `SIZE` consecutive addresses that starts at `OFFSET`.

Each read port is given one of three behaviours at elaboration time by `RD_MODE`, two bits per port:
- Code 0: the port reads combinationally.
- Code 1: the port captures its address at the clock edge and then selects the word from the live contents.
- Code 2: the port captures the selected word itself at the clock edge.

Both registered styles have a read enable that freezes their register when it is low.

A synchronous reset loads the array from the packed `INIT_VAL` parameter and clears the read registers. The block is meant for small register files and lookup stores where several agents need simultaneous access and a RAM macro would be too coarse.

Top module: `mpreg_mem`

## Requirements
- R1: While `rst` is high at a clock edge, word i is loaded with `INIT_VAL[i*WIDTH +: WIDTH]` (word 0 in the least significant bits). Both registered read styles then output zero until their enable is first seen high.
- R2: Bit b of the addressed word takes the port's data bit b only when enable bit b of that port is 1. All other bits keep their previous value, and a word hit by no enabled port is unchanged.
- R3: Ports are applied in ascending index order. When several ports enable the same bit of the same word in one cycle, the highest-indexed port's data is stored.
- R4: External address A selects word A−OFFSET. Only the addresses OFFSET to OFFSET+SIZE−1 reach the array.
- R5: A write whose address lies outside the window changes no word. A read whose address lies outside the window returns zero in all three read styles.
- R6: A combinational port (code 0) shows the word at its current address in the same cycle. A write appears on it right after the edge that performs the write.
- R7: An address-capturing port (code 1) with enable high takes its address at the edge. It then shows the current contents of that word, so a write at that same edge is already visible after the edge.
- R8: A data-capturing port (code 2) with enable high stores at the edge the word as it was before that edge's writes.
- R9: With read enable low at an edge, a code 2 port keeps its output. A code 1 port keeps its captured address and keeps following that word's contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock shared by all write ports and read registers |
| rst | input | 1 | Synchronous active-high reset; loads initial contents |
| wr_en | input | NWR*WIDTH | Per-bit write enables, port p in slice p*WIDTH |
| wr_addr | input | NWR*ABITS | Write addresses, port p in slice p*ABITS |
| wr_data | input | NWR*WIDTH | Write data, port p in slice p*WIDTH |
| rd_en | input | NRD | Read enable per port; used by registered styles only |
| rd_addr | input | NRD*ABITS | Read addresses, port r in slice r*ABITS |
| rd_data | output | NRD*WIDTH | Read data, port r in slice r*WIDTH |

## Verification
The assertions check on every cycle that:
- an untouched word holds its value;
- a full-width write from the top port lands in its word;
- out-of-window reads give zero on the combinational and address-capturing ports;
- a disabled data-capturing port holds its output.

The pre-edge versus post-edge visibility of the two registered styles can only be shown by the bench's scenarios. The same holds for port priority on partially overlapping enables, and for the exact word that each offset address reaches. The bench drives these cases and compares each against its own model of the array.

// File: rtl/mpreg_mem.sv
module mpreg_mem #(
  parameter int WIDTH  = 8,
  parameter int SIZE   = 8,
  parameter int ABITS  = 4,
  parameter int OFFSET = 4,
  parameter int NWR    = 3,
  parameter int NRD    = 3,
  parameter logic [2*NRD-1:0]      RD_MODE  = 6'b10_01_00,
  parameter logic [SIZE*WIDTH-1:0] INIT_VAL = 64'hA7A6A5A4A3A2A1A0
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NWR*WIDTH-1:0]   wr_en,
  input  logic [NWR*ABITS-1:0]   wr_addr,
  input  logic [NWR*WIDTH-1:0]   wr_data,
  input  logic [NRD-1:0]         rd_en,
  input  logic [NRD*ABITS-1:0]   rd_addr,
  output logic [NRD*WIDTH-1:0]   rd_data
);
  localparam int IW = (SIZE > 1) ? $clog2(SIZE) : 1;
  localparam logic [ABITS-1:0] OFS = ABITS'(OFFSET);

  function automatic logic in_rng(input logic [ABITS-1:0] a);
    int unsigned ua;
    ua = a;
    return (ua >= OFFSET) && (ua < OFFSET + SIZE);
  endfunction

  function automatic logic [IW-1:0] word_of(input logic [ABITS-1:0] a);
    return IW'(a - OFS);
  endfunction

  logic [WIDTH-1:0] mem      [SIZE];
  logic [WIDTH-1:0] mem_nxt  [SIZE];
  logic [WIDTH-1:0] wen_p    [NWR];
  logic [WIDTH-1:0] wdat_p   [NWR];
  logic [SIZE-1:0]  whit     [NWR];
  logic [SIZE-1:0]  wany;

  for (genvar p = 0; p < NWR; p++) begin : g_wport
    assign wen_p[p]  = wr_en[p*WIDTH +: WIDTH];
    assign wdat_p[p] = wr_data[p*WIDTH +: WIDTH];
    for (genvar w = 0; w < SIZE; w++) begin : g_dec
      assign whit[p][w] = in_rng(wr_addr[p*ABITS +: ABITS]) &&
                          (word_of(wr_addr[p*ABITS +: ABITS]) == IW'(w));
    end
  end

  always_comb begin
    for (int w = 0; w < SIZE; w++) begin
      mem_nxt[w] = mem[w];
      wany[w]    = 1'b0;
      for (int p = 0; p < NWR; p++) begin
        if (whit[p][w]) begin
          mem_nxt[w] = (mem_nxt[w] & ~wen_p[p]) | (wdat_p[p] & wen_p[p]);
          wany[w]    = wany[w] | (|wen_p[p]);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int w = 0; w < SIZE; w++) begin
      if (rst) mem[w] <= INIT_VAL[w*WIDTH +: WIDTH];
      else     mem[w] <= mem_nxt[w];
    end
  end

  for (genvar w = 0; w < SIZE; w++) begin : g_wchk
    a_r2_idle_word_holds: assert property (@(posedge clk) disable iff (rst)
      !wany[w] |=> mem[w] == $past(mem[w]));
    a_r3_top_port_full_write: assert property (@(posedge clk) disable iff (rst)
      (whit[NWR-1][w] && (&wen_p[NWR-1])) |=> mem[w] == $past(wdat_p[NWR-1]));
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rport
    localparam logic [1:0] MODE = RD_MODE[2*r +: 2];
    logic [ABITS-1:0] ra;
    logic [WIDTH-1:0] sel_q;
    logic [WIDTH-1:0] out_q;
    assign ra = rd_addr[r*ABITS +: ABITS];
    assign rd_data[r*WIDTH +: WIDTH] = out_q;

    if (MODE == 2'd1) begin : g_areg
      logic [ABITS-1:0] ahold;
      logic             hval;
      always_ff @(posedge clk) begin
        if (rst) begin
          ahold <= '0;
          hval  <= 1'b0;
        end else if (rd_en[r]) begin
          ahold <= ra;
          hval  <= 1'b1;
        end
      end
      assign sel_q = in_rng(ahold) ? mem[word_of(ahold)] : '0;
      assign out_q = hval ? sel_q : '0;
      a_r5_areg_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_en[r] && !in_rng(ra)) |=> out_q == '0);
    end else if (MODE == 2'd2) begin : g_dreg
      logic [WIDTH-1:0] dhold;
      assign sel_q = in_rng(ra) ? mem[word_of(ra)] : '0;
      always_ff @(posedge clk) begin
        if (rst)           dhold <= '0;
        else if (rd_en[r]) dhold <= sel_q;
      end
      assign out_q = dhold;
      a_r9_dreg_hold: assert property (@(posedge clk) disable iff (rst)
        !rd_en[r] |=> $stable(out_q));
    end else begin : g_async
      assign sel_q = in_rng(ra) ? mem[word_of(ra)] : '0;
      assign out_q = sel_q;
      a_r5_async_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        !in_rng(ra) |-> out_q == '0);
    end
  end
endmodule

// File: tb/mpreg_mem_tb_top.sv
module mpreg_mem_tb_top;
  localparam int W = 8, N = 8, AB = 4, OF = 4, NW = 3, NR = 3;

  logic clk = 1'b0;
  logic rst;
  logic [NW*W-1:0]  wr_en, wr_data;
  logic [NW*AB-1:0] wr_addr;
  logic [NR-1:0]    rd_en;
  logic [NR*AB-1:0] rd_addr;
  logic [NR*W-1:0]  rd_data;

  int total = 0, bad = 0;
  logic [W-1:0] refm [N];

  always #4 clk = ~clk;

  mpreg_mem dut_i (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data));

  task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [W-1:0] model_rd(input int a);
    return (a >= OF && a < OF + N) ? refm[a-OF] : '0;
  endfunction

  task automatic clr();
    wr_en = '0; wr_data = '0; wr_addr = '0; rd_en = '0;
  endtask

  task automatic set_wr(input int p, input int a, input logic [W-1:0] d, input logic [W-1:0] e);
    wr_addr[p*AB +: AB] = AB'(a);
    wr_data[p*W +: W] = d;
    wr_en[p*W +: W] = e;
  endtask

  task automatic set_rd(input int r, input int a, input logic e);
    rd_addr[r*AB +: AB] = AB'(a);
    rd_en[r] = e;
  endtask

  task automatic step();
    for (int p = 0; p < NW; p++) begin
      int a;
      a = int'(wr_addr[p*AB +: AB]);
      if (a >= OF && a < OF + N)
        refm[a-OF] = (refm[a-OF] & ~wr_en[p*W +: W]) | (wr_data[p*W +: W] & wr_en[p*W +: W]);
    end
    @(posedge clk);
    #1;
  endtask

  task automatic peek(input int a, output logic [W-1:0] d);
    rd_addr[0 +: AB] = AB'(a);
    #1;
    d = rd_data[0 +: W];
  endtask

  task automatic sweep(input string tag);
    logic [W-1:0] d;
    for (int a = OF; a < OF + N; a++) begin
      peek(a, d);
      chk(tag, d, model_rd(a));
    end
  endtask

  task automatic t_reset();
    for (int i = 0; i < N; i++) refm[i] = 8'hA0 + 8'(i);
    sweep("R1 init contents");
    chk("R1 areg zero after reset", rd_data[W +: W], 8'h00);
    chk("R1 dreg zero after reset", rd_data[2*W +: W], 8'h00);
  endtask

  task automatic t_bit_enable();
    logic [W-1:0] d;
    clr();
    set_wr(0, 5, 8'hFF, 8'h0F);
    step();
    clr();
    peek(5, d);
    chk("R2 partial enable", d, 8'hAF);
    sweep("R2 other words intact");
  endtask

  task automatic t_priority();
    logic [W-1:0] d;
    clr();
    set_wr(0, 6, 8'h11, 8'hFF);
    set_wr(2, 6, 8'h22, 8'hFF);
    step();
    clr();
    peek(6, d);
    chk("R3 higher port wins", d, 8'h22);
    set_wr(1, 7, 8'h33, 8'hFF);
    set_wr(2, 7, 8'h44, 8'hF0);
    step();
    clr();
    peek(7, d);
    chk("R3 overlap merge by bit", d, 8'h43);
  endtask

  task automatic t_offset_range();
    logic [W-1:0] d;
    clr();
    set_wr(0, 3, 8'h55, 8'hFF);
    set_wr(1, 12, 8'h66, 8'hFF);
    set_wr(2, 15, 8'h77, 8'hFF);
    step();
    clr();
    sweep("R5 out of window write ignored");
    peek(3, d);  chk("R5 read below window", d, 8'h00);
    peek(12, d); chk("R5 read above window", d, 8'h00);
    set_wr(0, OF, 8'h3C, 8'hFF);
    set_wr(1, OF + N - 1, 8'hC3, 8'hFF);
    step();
    clr();
    peek(OF, d);         chk("R4 lowest address is word 0", d, 8'h3C);
    peek(OF + N - 1, d); chk("R4 highest address is last word", d, 8'hC3);
  endtask

  task automatic t_async_edge();
    logic [W-1:0] d;
    clr();
    set_wr(1, 9, 8'h5A, 8'hFF);
    set_rd(0, 9, 1'b0);
    #1;
    d = rd_data[0 +: W];
    chk("R6 async before edge", d, model_rd(9));
    step();
    clr();
    chk("R6 async after edge", rd_data[0 +: W], 8'h5A);
  endtask

  task automatic t_registered_modes();
    logic [W-1:0] old;
    old = model_rd(10);
    clr();
    set_wr(0, 10, 8'h77, 8'hFF);
    set_rd(1, 10, 1'b1);
    set_rd(2, 10, 1'b1);
    step();
    clr();
    chk("R7 areg sees same-edge write", rd_data[W +: W], 8'h77);
    chk("R8 dreg sees pre-edge word", rd_data[2*W +: W], old);
    set_wr(0, 10, 8'h88, 8'hFF);
    set_rd(1, 4, 1'b0);
    set_rd(2, 4, 1'b0);
    step();
    clr();
    chk("R9 areg keeps address, follows word", rd_data[W +: W], 8'h88);
    chk("R9 dreg keeps output", rd_data[2*W +: W], old);
    set_rd(1, 13, 1'b1);
    set_rd(2, 4, 1'b1);
    step();
    clr();
    chk("R5 areg unmapped read", rd_data[W +: W], 8'h00);
    chk("R8 dreg new address", rd_data[2*W +: W], model_rd(4));
    set_rd(2, 2, 1'b1);
    step();
    clr();
    chk("R5 dreg unmapped read", rd_data[2*W +: W], 8'h00);
  endtask

  task automatic t_mixed_sweep();
    for (int k = 0; k < 20; k++) begin
      clr();
      for (int p = 0; p < NW; p++)
        set_wr(p, (k * 3 + p * 5) % 16, 8'((k * 37 + p * 91) & 8'hFF), 8'((k * 53 + p * 29) | p));
      step();
    end
    clr();
    sweep("R3 mixed collisions vs model");
  endtask

  initial begin
    rst = 1'b1;
    clr();
    rd_addr = '0;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    @(posedge clk);
    #1;
    t_reset();
    t_bit_enable();
    t_priority();
    t_offset_range();
    t_async_edge();
    t_registered_modes();
    t_mixed_sweep();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 50000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule